// File: doc/BRIEF.md
# Strap-Sampled Dual-Function Parity Pins

This block owns a small group of shared chip pins that serve two purposes in turn. While reset is held, the pins are inputs. The block latches their levels at reset exit as configuration straps: one disables the on-chip processor, one selects the bus width, one selects three-state operation. After that, a software-controlled enable bit can turn the same pins into drivers. They then carry even parity for each byte lane of a 16-bit data bus, plus a flag that marks bus cycles with valid parity.

The enable bit is cleared by reset. A write to it is honoured only once the straps have been latched, so setting it can never disturb strap sampling. Once enabled, parity is driven on every bus cycle. A read and a write are treated the same way. Parity is combinational and appears in the same cycle as the data. The pads and the pull resistors that preset the strap levels sit outside the block.

Top module: `strap_parity_pins`

## Requirements
- R1: While `rst_n` is low, `pin_oe` and `pin_out` are all zero and `strap_cfg` reads zero, whatever the bus and write inputs do. The enable bit is cleared by reset.
- R2: The straps are captured on the first rising clock edge at which `rst_n` is high: `strap_cfg[0]` (processor disable) takes `pin_in[0]`, `strap_cfg[1]` (bus width) takes `pin_in[1]`, and `strap_cfg[2]` (three-state select) takes `pin_in[2]`. Before that edge, `strap_cfg` reads zero.
- R3: After capture, `strap_cfg` holds its value until the next reset, whatever `pin_in` does.
- R4: A write with `cfg_we` high loads `cfg_wdata` into the enable bit at the next rising edge. A write presented at the strap capture edge is ignored, and so are writes during reset.
- R5: While the enable bit is 0, `pin_oe` and `pin_out` are all zero regardless of bus activity.
- R6: While enabled, and with `bus_valid` and `bus_be[i]` both high, `pin_oe[i]` is 1. `pin_out[i]` is then the even-parity bit of byte lane i (lane 0 = `bus_data[7:0]`, lane 1 = `bus_data[15:8]`), so the lane plus its parity bit holds an even number of ones. The bit appears in the same cycle as the data.
- R7: Parity is driven on read and write cycles alike: any cycle with `bus_valid` high is a parity cycle.
- R8: While enabled, `pin_oe[2]` is 1. `pin_out[2]` is 1 exactly when `bus_valid` is high and at least one byte strobe is set.
- R9: While enabled, a lane whose strobe is low, or any lane when `bus_valid` is low, has `pin_oe` and `pin_out` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_in | input | 3 | Levels seen on the shared pins |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_wdata | input | 1 | Value written to the enable bit |
| bus_valid | input | 1 | A bus cycle (read or write) is in progress |
| bus_be | input | 2 | Byte-lane strobes |
| bus_data | input | 16 | Bus data |
| pin_oe | output | 3 | Per-pin output enable |
| pin_out | output | 3 | Per-pin driven value |
| strap_cfg | output | 3 | Latched strap levels: [0] processor disable, [1] bus width, [2] three-state |

## Verification
A wrong capture flag shows up at `strap_cfg` one edge after reset release: the value is either latched too early or keeps following the pins afterwards. A wrong enable bit shows up as driven output enables in the very cycle after the bad write. A wrong lane parity shows up on `pin_out` in the same cycle that the data is presented. Every stimulus cycle is therefore checked at the following falling edge.

// File: rtl/strap_parity_pkg.sv
package strap_parity_pkg;
  // strap bit meaning, fixed by pin position
  localparam int unsigned STRAP_CPU_OFF  = 0;
  localparam int unsigned STRAP_BUS_WIDE = 1;
  localparam int unsigned STRAP_TRISTATE = 2;

  // even parity: the bit that makes the total count of ones even
  function automatic logic even_par8(input logic [7:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/sp_strap_capture.sv
module sp_strap_capture #(
  parameter int unsigned PINS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] strap_q,
  output logic            captured_q
);
  logic [PINS-1:0] strap_d;
  logic            captured_d;
  logic            load;

  always_comb begin
    load       = !captured_q;
    captured_d = captured_q;
    strap_d    = strap_q;
    if (load) begin
      captured_d = 1'b1;
      strap_d    = pin_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured_q <= 1'b0;
      strap_q    <= '0;
    end else begin
      captured_q <= captured_d;
      strap_q    <= strap_d;
    end
  end
endmodule

// File: rtl/sp_enable_reg.sv
module sp_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic captured,
  input  logic wr_en,
  input  logic wr_bit,
  output logic en_q
);
  logic en_d;
  logic accept;

  always_comb begin
    accept = captured && wr_en;
    en_d   = en_q;
    if (accept) en_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/sp_lane_parity.sv
module sp_lane_parity #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_data,
  input  logic              active,
  output logic              par_out,
  output logic              par_oe
);
  logic par_raw;

  generate
    if (LANE_W == 8) begin : g_byte
      assign par_raw = strap_parity_pkg::even_par8(lane_data);
    end else begin : g_generic
      assign par_raw = ^lane_data;
    end
  endgenerate

  assign par_oe  = active;
  assign par_out = active & par_raw;
endmodule

// File: rtl/strap_parity_pins.sv
module strap_parity_pins #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES:0]           pin_in,
  input  logic                     cfg_we,
  input  logic                     cfg_wdata,
  input  logic                     bus_valid,
  input  logic [LANES-1:0]         bus_be,
  input  logic [LANES*LANE_W-1:0]  bus_data,
  output logic [LANES:0]           pin_oe,
  output logic [LANES:0]           pin_out,
  output logic [LANES:0]           strap_cfg
);
  localparam int unsigned PINS   = LANES + 1;
  localparam int unsigned FLAG_I = LANES;

  logic             captured_q;
  logic             en_q;
  logic             cycle_on;
  logic [LANES-1:0] lane_par;
  logic [LANES-1:0] lane_oe;

  sp_strap_capture #(.PINS(PINS)) u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .strap_q    (strap_cfg),
    .captured_q (captured_q)
  );

  sp_enable_reg u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .captured (captured_q),
    .wr_en    (cfg_we),
    .wr_bit   (cfg_wdata),
    .en_q     (en_q)
  );

  assign cycle_on = en_q & bus_valid;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sp_lane_parity #(.LANE_W(LANE_W)) u_par (
      .lane_data (bus_data[g*LANE_W +: LANE_W]),
      .active    (cycle_on & bus_be[g]),
      .par_out   (lane_par[g]),
      .par_oe    (lane_oe[g])
    );
  end

  always_comb begin
    pin_oe  = '0;
    pin_out = '0;
    pin_oe[LANES-1:0]  = lane_oe;
    pin_out[LANES-1:0] = lane_par;
    pin_oe[FLAG_I]     = en_q;
    pin_out[FLAG_I]    = cycle_on & (|bus_be);
  end
endmodule

// File: rtl/strap_parity_pins_checker.sv
module strap_parity_pins_checker #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES:0]          pin_in,
  input logic                    cfg_we,
  input logic                    cfg_wdata,
  input logic [LANES*LANE_W-1:0] bus_data,
  input logic [LANES:0]          pin_oe,
  input logic [LANES:0]          pin_out,
  input logic [LANES:0]          strap_cfg,
  input logic                    captured,
  input logic                    en_q
);
  a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(captured) |-> strap_cfg == $past(pin_in));

  a_r3_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> $stable(strap_cfg));

  a_r4_enable_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> ($past(captured) && $past(cfg_we) && $past(cfg_wdata)));

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pin_oe == '0 && pin_out == '0));

  a_r8_flag_driven: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> pin_oe[LANES]);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r6_even_lane: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[g] |-> (^{pin_out[g], bus_data[g*LANE_W +: LANE_W]}) == 1'b0);
  end
endmodule

bind strap_parity_pins strap_parity_pins_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_in    (pin_in),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .bus_data  (bus_data),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .strap_cfg (strap_cfg),
  .captured  (captured_q),
  .en_q      (en_q)
);

// File: tb/strap_parity_pins_bench.sv
`timescale 1ns/100ps
module strap_parity_pins_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  pin_in;
  logic        cfg_we, cfg_wdata, bus_valid;
  logic [1:0]  bus_be;
  logic [15:0] bus_data;
  logic [2:0]  pin_oe, pin_out, strap_cfg;

  always #2.5 clk = ~clk;

  strap_parity_pins u_strap_parity_pins (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_be(bus_be), .bus_data(bus_data),
    .pin_oe(pin_oe), .pin_out(pin_out), .strap_cfg(strap_cfg)
  );

  typedef struct {
    logic [2:0] oe;
    logic [2:0] out;
    logic [2:0] strap;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the requirements
  logic       m_cap, m_en;
  logic [2:0] m_strap;

  task automatic apply(input logic v, input logic [1:0] be, input logic [15:0] d,
                       input logic we, input logic wd, input logic [2:0] pins,
                       input logic rel, input string req);
    exp_t e;
    @(posedge clk); #1;
    if (rel) rst_n = 1'b1;
    bus_valid = v; bus_be = be; bus_data = d;
    cfg_we = we; cfg_wdata = wd; pin_in = pins;
    if (m_en && rst_n) begin
      e.oe  = {1'b1, v & be[1], v & be[0]};
      e.out = {v & (|be), v & be[1] & (^d[15:8]), v & be[0] & (^d[7:0])};
    end else begin
      e.oe = 3'b000; e.out = 3'b000;
    end
    e.strap = m_strap;
    e.req   = req;
    q.push_back(e);
    if (rst_n) begin
      if (!m_cap) begin m_cap = 1'b1; m_strap = pins; end
      else if (we) m_en = wd;
    end
  endtask

  task automatic enter_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    m_cap = 1'b0; m_en = 1'b0; m_strap = 3'b000;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pin_oe !== e.oe || pin_out !== e.out || strap_cfg !== e.strap) begin
        fails++;
        $display("FAIL %s: oe=%b out=%b strap=%b expected oe=%b out=%b strap=%b",
                 e.req, pin_oe, pin_out, strap_cfg, e.oe, e.out, e.strap);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_in = 3'b101; cfg_we = 0; cfg_wdata = 0;
    bus_valid = 0; bus_be = 0; bus_data = 0;
    m_cap = 0; m_en = 0; m_strap = 0;
    // R1: reset holds everything quiet, writes ignored
    apply(1, 2'b11, 16'h1234, 1, 1, 3'b101, 0, "R1");
    apply(1, 2'b11, 16'h00FF, 1, 1, 3'b101, 0, "R1");
    // R2 / R4: release; straps zero before edge, write at capture edge ignored
    apply(1, 2'b11, 16'h0180, 1, 1, 3'b101, 1, "R2");
    // R2 / R5: straps latched, still disabled; now write enable
    apply(1, 2'b11, 16'h0180, 1, 1, 3'b010, 0, "R5");
    // R6 / R7 / R8 enabled, various data
    apply(1, 2'b11, 16'h0000, 0, 0, 3'b010, 0, "R6");
    apply(1, 2'b11, 16'h0180, 0, 0, 3'b111, 0, "R6");
    apply(1, 2'b01, 16'h0301, 0, 0, 3'b000, 0, "R9");
    apply(1, 2'b10, 16'h7F00, 0, 0, 3'b010, 0, "R9");
    apply(1, 2'b11, 16'hA5C3, 0, 0, 3'b001, 0, "R7");
    apply(0, 2'b11, 16'hFFFF, 0, 0, 3'b110, 0, "R8");
    apply(1, 2'b00, 16'h0101, 0, 0, 3'b010, 0, "R8");
    apply(1, 2'b11, 16'hFE01, 0, 0, 3'b011, 0, "R3");
    // R4: disable by writing 0
    apply(1, 2'b11, 16'h1111, 1, 0, 3'b010, 0, "R4");
    apply(1, 2'b11, 16'h1111, 0, 0, 3'b010, 0, "R5");
    apply(1, 2'b11, 16'h0F0E, 1, 1, 3'b010, 0, "R4");
    apply(1, 2'b11, 16'h0F0E, 0, 0, 3'b010, 0, "R6");
    // second reset while enabled
    enter_reset();
    apply(1, 2'b11, 16'h0101, 1, 1, 3'b011, 0, "R1");
    apply(1, 2'b11, 16'h0101, 0, 0, 3'b011, 1, "R2");
    apply(1, 2'b11, 16'h0101, 0, 0, 3'b100, 0, "R2");
    apply(1, 2'b11, 16'h0101, 0, 0, 3'b100, 0, "R3");
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule